// File: doc/BRIEF.md
# Delay-Line Tap Controller for a Delay-Locked Loop

This block closes the phase loop of an all-digital delay-locked loop. A phase detector outside the block samples the output clock with the reference clock, with no divider in the loop, and hands over one bit per reference cycle. The bit says whether the output edge arrived late or early. The controller turns that bit into a count of active delay elements. A late result removes one element and an early result adds one.

To keep the loop stable, the count moves only on every second reference edge. It moves by at most one element per decision and is clamped at both ends of the chain. The count is presented to the delay line in two forms, a thermometer code and a one-hot tap select. A lock flag rises once the decisions begin to alternate between the two directions, which shows that the output edge is dithering around the reference edge.

Top module: `dll_phase_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the controller returns to its reset state: `tap_cnt` equals MAX_TAPS/2 (8 by default), `locked` is 0, and both tap-select outputs encode that count.
- R2: A decision made with `pd_late`=1 (output late, shift toward shorter delay) lowers `tap_cnt` by exactly one.
- R3: A decision made with `pd_late`=0 (output early, shift toward longer delay) raises `tap_cnt` by exactly one. No decision changes the count by more than one.
- R4: Decisions take place only on every second rising edge. The first is on the second edge at which `rst_n` is high, the next on the fourth, and so on. Each decision uses the `pd_late` value present at that edge. On all other edges `tap_cnt` holds its value, whatever `pd_late` is.
- R5: A late decision when `tap_cnt` is 0 leaves it at 0.
- R6: An early decision when `tap_cnt` is MAX_TAPS leaves it at MAX_TAPS.
- R7: `locked` goes to 1 on the edge of the LOCK_RUN-th (4 by default) consecutive decision in a run where every decision has the opposite direction of the one before it. It stays at 1 while the alternation continues. The first decision after reset starts a run.
- R8: A decision in the same direction as the one before it clears `locked` on that edge, and the next run starts from that decision.
- R9: `tap_therm[i]` is 1 exactly when i < `tap_cnt`. `tap_onehot[i]` is 1 exactly when i equals `tap_cnt`, with bit 0 meaning no active element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_late | input | 1 | Phase detector sample: 1 = output edge late, 0 = output edge early |
| tap_cnt | output | CNT_W (5) | Number of active delay elements, 0..MAX_TAPS |
| tap_therm | output | MAX_TAPS (16) | Thermometer code of the active elements |
| tap_onehot | output | MAX_TAPS+1 (17) | One-hot select of the active tap |
| locked | output | 1 | Decisions are alternating; the loop is dithering at the lock point |

## Verification
If the pacing phase is inverted or lost, `tap_cnt` moves on odd edges or on two consecutive edges. The edge-by-edge comparison flags this on the first or second edge after reset. A wrong clamp shows as soon as the count is driven against either end of the chain: it wraps to the far end or gets stuck one short of the limit. A corrupted run counter or a corrupted stored direction shows on `locked` one decision early, one decision late, or after a repeated direction. Each of these appears within a few decisions of the directed alternating and repeating patterns.

// File: rtl/dll_pkg.sv
// Shared types for the delay-line tap controller.
package dll_pkg;
    // Direction of one loop decision; the encoding equals the detector bit.
    typedef enum logic {
        SHIFT_LONGER  = 1'b0,   // output early: add a delay element
        SHIFT_SHORTER = 1'b1    // output late: remove a delay element
    } shift_dir_t;
endpackage

// File: rtl/dll_dec_pacer.sv
// Decision pacer: strobes once every two reference edges.
// Assumes: synchronous active-low reset; the first strobe falls on the
// second edge after reset is released.
module dll_dec_pacer (
    input  logic clk,
    input  logic rst_n,
    output logic dec_en
);
    logic phase_q;

    // Toggle the pacing phase on each reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    assign dec_en = phase_q;

    // R4: strobes never fall on two consecutive edges.
    p_no_double_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |=> !dec_en);
endmodule

// File: rtl/dll_tap_counter.sv
// Saturating linear tap counter: one element per decision, clamped to
// 0..MAX_TAPS. Assumes: dec_en is a single-cycle strobe from the pacer.
module dll_tap_counter
    import dll_pkg::*;
#(
    parameter int MAX_TAPS = 16,
    parameter int CNT_W    = $clog2(MAX_TAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_en,
    input  shift_dir_t       dir,
    output logic [CNT_W-1:0] tap_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_TAPS);
    localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(MAX_TAPS / 2);

    logic at_min, at_max;
    assign at_min = (tap_cnt == '0);
    assign at_max = (tap_cnt == CNT_MAX);

    // Step the count once per decision, holding at either end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tap_cnt <= CNT_MID;
        else if (dec_en) begin
            if (dir == SHIFT_SHORTER && !at_min)
                tap_cnt <= tap_cnt - 1'b1;
            else if (dir == SHIFT_LONGER && !at_max)
                tap_cnt <= tap_cnt + 1'b1;
        end
    end

    // R3: the count moves by at most one element per edge.
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tap_cnt == $past(tap_cnt)) ||
                 (tap_cnt == $past(tap_cnt) + 1'b1) ||
                 (tap_cnt == $past(tap_cnt) - 1'b1));
    // R5/R6: the count never leaves the chain.
    p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tap_cnt <= CNT_MAX);
    // R5: a late decision at zero leaves zero.
    p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && at_min && dir == SHIFT_SHORTER) |=> (tap_cnt == '0));
endmodule

// File: rtl/dll_lock_detect.sv
// Lock detector: counts consecutive decisions that alternate direction
// and raises locked after LOCK_RUN of them. Assumes LOCK_RUN >= 2.
module dll_lock_detect
    import dll_pkg::*;
#(
    parameter int LOCK_RUN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_en,
    input  shift_dir_t dir,
    output logic       locked
);
    localparam int               RUN_W   = $clog2(LOCK_RUN);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_RUN - 1);

    logic [RUN_W-1:0] run_q;
    shift_dir_t       prev_q;
    logic             have_prev_q;
    logic             flips;

    assign flips = have_prev_q && (dir != prev_q);

    // Track the direction changes of the decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= '0;
            prev_q      <= SHIFT_LONGER;
            have_prev_q <= 1'b0;
        end else if (dec_en) begin
            prev_q      <= dir;
            have_prev_q <= 1'b1;
            if (!flips)              run_q <= '0;
            else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
        end
    end

    assign locked = (run_q == RUN_TOP);

    // R8: a repeated direction drops lock on that edge.
    p_repeat_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && have_prev_q && dir == prev_q) |=> !locked);
    // R7: lock can only rise on a decision edge.
    p_lock_on_decision_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_en && !locked) |=> !locked);
endmodule

// File: rtl/dll_tap_decode.sv
// Tap decoder: turns the element count into a thermometer code and a
// one-hot tap select. Purely combinational.
module dll_tap_decode #(
    parameter int MAX_TAPS = 16,
    parameter int CNT_W    = $clog2(MAX_TAPS + 1)
) (
    input  logic [CNT_W-1:0]  tap_cnt,
    output logic [MAX_TAPS-1:0] tap_therm,
    output logic [MAX_TAPS:0]   tap_onehot
);
    for (genvar i = 0; i < MAX_TAPS; i++) begin : g_therm
        assign tap_therm[i] = (CNT_W'(i) < tap_cnt);
    end
    for (genvar j = 0; j <= MAX_TAPS; j++) begin : g_onehot
        assign tap_onehot[j] = (tap_cnt == CNT_W'(j));
    end
endmodule

// File: rtl/dll_phase_ctrl.sv
// Delay-locked loop tap controller (top). Takes the sampled early/late bit
// from the phase detector, paces decisions to one per two reference edges,
// steps a saturating element count and reports lock on alternation.
// Assumes: clk is the reference clock; pd_late is already synchronous.
module dll_phase_ctrl
    import dll_pkg::*;
#(
    parameter int MAX_TAPS = 16,
    parameter int LOCK_RUN = 4,
    parameter int CNT_W    = $clog2(MAX_TAPS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pd_late,
    output logic [CNT_W-1:0]    tap_cnt,
    output logic [MAX_TAPS-1:0] tap_therm,
    output logic [MAX_TAPS:0]   tap_onehot,
    output logic                locked
);
    logic       dec_en;
    shift_dir_t dir;

    assign dir = shift_dir_t'(pd_late);

    dll_dec_pacer u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec_en (dec_en)
    );

    dll_tap_counter #(.MAX_TAPS(MAX_TAPS), .CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_en  (dec_en),
        .dir     (dir),
        .tap_cnt (tap_cnt)
    );

    dll_lock_detect #(.LOCK_RUN(LOCK_RUN)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .dec_en (dec_en),
        .dir    (dir),
        .locked (locked)
    );

    dll_tap_decode #(.MAX_TAPS(MAX_TAPS), .CNT_W(CNT_W)) u_decode (
        .tap_cnt    (tap_cnt),
        .tap_therm  (tap_therm),
        .tap_onehot (tap_onehot)
    );

    // R4: without a decision strobe the count holds.
    p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> $stable(tap_cnt));
    // R9: exactly one tap selected, matching the thermometer population.
    p_select_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(tap_onehot) && ($countones(tap_therm) == int'(tap_cnt)));
endmodule

// File: tb/tb_dll_phase_ctrl.sv
module tb_dll_phase_ctrl;
    localparam int MAX_TAPS = 16;
    localparam int LOCK_RUN = 4;
    localparam int CNT_W    = $clog2(MAX_TAPS + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                pd_late = 1'b0;
    logic [CNT_W-1:0]    tap_cnt;
    logic [MAX_TAPS-1:0] tap_therm;
    logic [MAX_TAPS:0]   tap_onehot;
    logic                locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state, written from the requirements.
    int m_cnt, m_run, m_cyc;
    bit m_prev, m_havep;

    dll_phase_ctrl #(.MAX_TAPS(MAX_TAPS), .LOCK_RUN(LOCK_RUN)) dut (
        .clk(clk), .rst_n(rst_n), .pd_late(pd_late),
        .tap_cnt(tap_cnt), .tap_therm(tap_therm),
        .tap_onehot(tap_onehot), .locked(locked)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [MAX_TAPS-1:0] exp_therm(int c);
        logic [MAX_TAPS-1:0] v = '0;
        for (int i = 0; i < MAX_TAPS; i++) v[i] = (i < c);
        return v;
    endfunction

    function automatic logic [MAX_TAPS:0] exp_onehot(int c);
        logic [MAX_TAPS:0] v = '0;
        v[c] = 1'b1;
        return v;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string req_cnt);
        chk(req_cnt, "tap_cnt", tap_cnt, m_cnt);
        chk("R9", "tap_therm", tap_therm, exp_therm(m_cnt));
        chk("R9", "tap_onehot", tap_onehot, exp_onehot(m_cnt));
        chk((m_run == LOCK_RUN - 1) ? "R7" : "R8", "locked",
            locked, (m_run == LOCK_RUN - 1));
    endtask

    // Drive one cycle of pd, update the model, compare at the falling edge.
    task automatic step(bit pd);
        string tag;
        pd_late = pd;
        @(posedge clk);
        m_cyc++;
        if (m_cyc % 2 != 0) tag = "R4";
        else begin
            if (pd && m_cnt == 0)              tag = "R5";
            else if (!pd && m_cnt == MAX_TAPS) tag = "R6";
            else                               tag = pd ? "R2" : "R3";
            if (pd && m_cnt > 0)               m_cnt--;
            if (!pd && m_cnt < MAX_TAPS)       m_cnt++;
            if (m_havep && pd != m_prev)
                m_run = (m_run < LOCK_RUN - 1) ? m_run + 1 : m_run;
            else
                m_run = 0;
            m_prev  = pd;
            m_havep = 1'b1;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_cnt = MAX_TAPS / 2; m_run = 0; m_cyc = 0;
        m_prev = 1'b0; m_havep = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // R5: drive late until the floor, then keep pushing.
        for (int k = 0; k < 24; k++) step(1'b1);
        // R6: drive early until the ceiling, then keep pushing.
        for (int k = 0; k < 44; k++) step(1'b0);
        // R7: alternate direction every decision.
        for (int k = 0; k < 14; k++) step(k[1]);
        // R8: repeat the same direction.
        for (int k = 0; k < 6; k++) step(1'b1);
        // R7 again after a mid-range reset, then break lock (R8).
        do_reset();
        for (int k = 0; k < 10; k++) step(k[1]);
        step(1'b0); step(1'b0);
        // R4: toggle pd on the non-decision edges only.
        for (int k = 0; k < 8; k++) step(k[0]);
        // Random mix: runs of random bits, alternation and steady pushes.
        for (int blk = 0; blk < 300; blk++) begin
            int mode = $urandom_range(0, 2);
            for (int k = 0; k < 12; k++) begin
                case (mode)
                    0:       step(1'($urandom_range(0, 1)));
                    1:       step(k[1]);
                    default: step(blk[0]);
                endcase
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule